// File: doc/BRIEF.md
# Logarithmic Sample Compressor

This block turns a 16-bit two's-complement linear audio sample into an 8-bit companded codeword. Small amplitudes get many code steps and large amplitudes get few, so soft and loud signals both keep usable resolution in one byte. A per-sample law select chooses between the mu-law curve (constant 255) and the A-law curve (constant 87.6). Unlike the usual segment-and-step encoders, every code comes from the continuous logarithmic formula itself. That formula is evaluated once per table entry when the design is elaborated and is then held as a constant table.

The sign and the magnitude are handled separately. The magnitude is formed from the absolute value, with the most negative input clamped to full scale. Its upper bits index the table, and the sign goes into the top bit of the codeword. Samples enter and codes leave through valid/ready handshakes. There are two register stages, and both freeze together when the consumer stalls.

Top module: `cmp_compressor`

## Requirements
- R1: While reset is held, and at the first sample after release, `out_valid` is 0 and `in_ready` is 1, whatever the value of `out_ready`.
- R2: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. A sample is taken on a rising edge where `in_valid` and `in_ready` are both high.
- R3: With `out_ready` held high, a sample accepted at rising edge k is presented with `out_valid` high after rising edge k+1, which is two clocks of latency.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_code` keeps its value on the next edge.
- R5: `out_code[7]` is 1 for a negative input and 0 otherwise. `out_code[6:0]` is the table magnitude, with no bit inversion.
- R6: The magnitude is |sample|, and -32768 is clamped to 32767. The table index is magnitude bits [14:5] (10 bits), and u = (2*index+1)/2048.
- R7: With `in_law` = 0 (mu-law), the magnitude code is round(127 * ln(1+255u) / ln(256)), rounding halves upward.
- R8: With `in_law` = 1 (A-law, A = 87.6), the magnitude code is round(127 * A*u / (1+ln A)) for u < 1/A and round(127 * (1+ln(A*u)) / (1+ln A)) for larger u.
- R9: A full-scale input yields magnitude code 127: 32767 gives 8'h7F and -32768 gives 8'hFF under either law.
- R10: The law is captured together with each sample, so back-to-back samples may use different laws and each is coded by its own law.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_sample | input | 16 | Two's-complement linear sample |
| in_law | input | 1 | Law select: 0 mu-law, 1 A-law |
| out_valid | output | 1 | Codeword present |
| out_ready | input | 1 | Consumer takes the codeword |
| out_code | output | 8 | Sign in bit 7, magnitude code in bits 6:0 |

## Verification
Two things can happen in the same cycle. A new sample with a different law enters stage one while the previous sample, of the other law, is being looked up. At the same time the consumer may stall, which freezes both stages at once. The bench drives alternating laws back to back while a pseudo-random pattern toggles `out_ready`. Every delivered code is compared in order against a formula computed in the bench, and every stalled cycle is checked to hold the previous code.

// File: rtl/compand_pkg.sv
package compand_pkg;

    typedef enum logic {
        LAW_MU = 1'b0,
        LAW_A  = 1'b1
    } law_e;

    localparam real MU_K = 255.0;
    localparam real A_K  = 87.6;

    // Rounds a non-negative real to nearest and clamps it into [0, top].
    function automatic int round_clip(input real v, input int top);
        int r;
        r = $rtoi(v + 0.5);
        if (r > top) r = top;
        if (r < 0)   r = 0;
        return r;
    endfunction

    // Normalised magnitude at the centre of table cell idx.
    function automatic real cell_centre(input int idx, input int depth);
        return (2.0 * idx + 1.0) / (2.0 * depth);
    endfunction

    function automatic int mu_code(input int idx, input int depth, input int top);
        real u;
        real f;
        u = cell_centre(idx, depth);
        f = $ln(1.0 + MU_K * u) / $ln(1.0 + MU_K);
        return round_clip(f * top, top);
    endfunction

    function automatic int a_code(input int idx, input int depth, input int top);
        real u;
        real f;
        u = cell_centre(idx, depth);
        if (u < 1.0 / A_K)
            f = (A_K * u) / (1.0 + $ln(A_K));
        else
            f = (1.0 + $ln(A_K * u)) / (1.0 + $ln(A_K));
        return round_clip(f * top, top);
    endfunction

endpackage

// File: rtl/cmp_mag_index.sv
module cmp_mag_index #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 10
) (
    input  logic [DATA_W-1:0] sample_i,
    output logic              sign_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int MAG_W = DATA_W - 1;
    localparam int LOW_W = MAG_W - IDX_W;

    logic [DATA_W-1:0] negated;
    logic [MAG_W-1:0]  mag;
    logic              is_min;

    always_comb begin
        negated = -sample_i;
        is_min  = (sample_i == {1'b1, {MAG_W{1'b0}}});
        if (!sample_i[DATA_W-1])
            mag = sample_i[MAG_W-1:0];
        else if (is_min)
            mag = {MAG_W{1'b1}};
        else
            mag = negated[MAG_W-1:0];
    end

    assign sign_o = sample_i[DATA_W-1];
    assign idx_o  = mag[MAG_W-1 -: IDX_W];

    if (LOW_W > 0) begin : g_low
        logic unused_low;
        assign unused_low = ^{mag[LOW_W-1:0], negated[DATA_W-1]};
    end else begin : g_nolow
        logic unused_neg;
        assign unused_neg = negated[DATA_W-1];
    end

endmodule

// File: rtl/cmp_law_rom.sv
module cmp_law_rom
    import compand_pkg::*;
#(
    parameter int   IDX_W = 10,
    parameter int   MAG_W = 7,
    parameter law_e LAW   = LAW_MU
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [MAG_W-1:0] code_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int TOP   = (1 << MAG_W) - 1;

    logic [MAG_W-1:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (LAW == LAW_MU) begin : g_mu
            localparam int C = mu_code(i, DEPTH, TOP);
            assign table_w[i] = MAG_W'(C);
        end else begin : g_a
            localparam int C = a_code(i, DEPTH, TOP);
            assign table_w[i] = MAG_W'(C);
        end
    end

    assign code_o = table_w[idx_i];

endmodule

// File: rtl/cmp_compressor.sv
module cmp_compressor
    import compand_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CODE_W = 8,
    parameter int IDX_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_law,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code
);
    localparam int MAG_W  = CODE_W - 1;
    localparam int N_LAWS = 2;

    typedef struct packed {
        logic             valid;
        logic             sign;
        law_e             law;
        logic [IDX_W-1:0] idx;
    } look_t;

    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] code;
    } emit_t;

    typedef struct packed {
        look_t look;
        emit_t emit;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic             advance;
    logic             in_sign;
    logic [IDX_W-1:0] in_idx;
    logic [MAG_W-1:0] rom_code [N_LAWS];
    logic [MAG_W-1:0] picked;

    cmp_mag_index #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mag (
        .sample_i (in_sample),
        .sign_o   (in_sign),
        .idx_o    (in_idx)
    );

    for (genvar l = 0; l < N_LAWS; l++) begin : g_rom
        cmp_law_rom #(
            .IDX_W (IDX_W),
            .MAG_W (MAG_W),
            .LAW   (law_e'(l))
        ) u_rom (
            .idx_i  (st_q.look.idx),
            .code_o (rom_code[l])
        );
    end

    assign advance = !st_q.emit.valid || out_ready;
    assign picked  = rom_code[st_q.look.law];

    always_comb begin
        st_d = st_q;
        if (advance) begin
            st_d.look.valid = in_valid;
            if (in_valid) begin
                st_d.look.sign = in_sign;
                st_d.look.law  = law_e'(in_law);
                st_d.look.idx  = in_idx;
            end
            st_d.emit.valid = st_q.look.valid;
            if (st_q.look.valid)
                st_d.emit.code = {st_q.look.sign, picked};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign in_ready  = advance;
    assign out_valid = st_q.emit.valid;
    assign out_code  = st_q.emit.code;

endmodule

// File: rtl/cmp_compressor_chk.sv
module cmp_compressor_chk #(
    parameter int DATA_W = 16,
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_sample,
    input logic              out_valid,
    input logic              out_ready,
    input logic [CODE_W-1:0] out_code
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    // R4: a stalled codeword stays put
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

    // R3: accepted sample emerges once the next stage advances
    assert_flow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_valid && in_ready) ##1 in_ready) |=> out_valid);

    // R5: negative input gives sign bit set
    assert_sign_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_valid && in_ready && in_sample[DATA_W-1]) ##1 in_ready) |=> out_code[CODE_W-1]);

    // R5: non-negative input gives sign bit clear
    assert_sign_pos_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_valid && in_ready && !in_sample[DATA_W-1]) ##1 in_ready) |=> !out_code[CODE_W-1]);

    // R9: most negative input maps to the all-ones codeword
    assert_full_scale_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_valid && in_ready && (in_sample == MOST_NEG)) ##1 in_ready) |=> (out_code == '1));

endmodule

bind cmp_compressor cmp_compressor_chk #(
    .DATA_W (DATA_W),
    .CODE_W (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sample (in_sample),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code)
);

// File: tb/tb_cmp_compressor.sv
`timescale 1ns/1ps
module tb_cmp_compressor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_sample = '0;
    logic        in_law = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [7:0]  out_code;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   cyc     = 0;
    bit   bp      = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [7:0] code;
        string      tag;
        int         cyc;
        bit         lat;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    cmp_compressor dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sample (in_sample),
        .in_law    (in_law),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_code  (out_code)
    );

    always @(negedge clk) cyc++;

    function automatic logic [7:0] model(input logic [15:0] s, input logic law);
        int  v;
        int  mag;
        int  idx;
        int  c;
        real u;
        real f;
        v   = int'($signed(s));
        mag = (v < 0) ? -v : v;
        if (mag > 32767) mag = 32767;
        idx = mag >> 5;
        u   = (2.0 * idx + 1.0) / 2048.0;
        if (!law)
            f = $ln(1.0 + 255.0 * u) / $ln(256.0);
        else if (u < 1.0 / 87.6)
            f = (87.6 * u) / (1.0 + $ln(87.6));
        else
            f = (1.0 + $ln(87.6 * u)) / (1.0 + $ln(87.6));
        c = $rtoi(f * 127.0 + 0.5);
        if (c > 127) c = 127;
        if (c < 0) c = 0;
        return {(v < 0), 7'(c)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive_ready();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp ? lfsr[0] : 1'b1;
    endtask

    task automatic send(input logic [15:0] s, input logic law, input string tag, input bit lat);
        item_t it;
        do begin
            @(negedge clk);
            drive_ready();
            in_valid  = 1'b1;
            in_sample = s;
            in_law    = law;
            #0.5;
        end while (!in_ready);
        it.code = model(s, law);
        it.tag  = tag;
        it.cyc  = cyc;
        it.lat  = lat;
        sb.push_back(it);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (sb.size() > 0 && guard < 100) begin
            @(negedge clk);
            in_valid  = 1'b0;
            out_ready = 1'b1;
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares delivered codes against the queue, checks stall hold and handshake.
    bit         hold_pend = 1'b0;
    logic [7:0] hold_code = '0;
    always @(negedge clk) begin
        item_t it;
        #1;
        if (rst_n) begin
            check("R2 in_ready", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
            if (hold_pend) begin
                check("R4 valid held", {31'd0, out_valid}, 32'd1);
                check("R4 code held", {24'd0, out_code}, {24'd0, hold_code});
            end
            hold_pend = out_valid && !out_ready;
            hold_code = out_code;
            if (out_valid && out_ready) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected output", 32'd1, 32'd0);
                end else begin
                    it = sb.pop_front();
                    check(it.tag, {24'd0, out_code}, {24'd0, it.code});
                    if (it.lat)
                        check("R3 latency", 32'(cyc - it.cyc), 32'd2);
                end
            end
        end else begin
            hold_pend = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    localparam int NV = 12;
    logic [15:0] vals [NV] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h001F, 16'h0020,
                               16'h0064, 16'hFF9C, 16'h03E8, 16'h7FFF, 16'h8000,
                               16'h8001, 16'h3039};

    initial begin
        // R1: reset state with consumer stalled
        out_ready = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready in reset", {31'd0, in_ready}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #0.5;
        check("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 in_ready after reset", {31'd0, in_ready}, 32'd1);

        // R5 R6 R7 R9: mu-law directed values with latency check
        for (int i = 0; i < NV; i++) send(vals[i], 1'b0, "R7 mu-law directed", 1'b1);
        drain();
        // R5 R6 R8 R9: A-law directed values
        for (int i = 0; i < NV; i++) send(vals[i], 1'b1, "R8 A-law directed", 1'b1);
        drain();
        // R9: full-scale endpoints
        send(16'h7FFF, 1'b0, "R9 +full mu", 1'b1);
        send(16'h8000, 1'b1, "R9 -full A", 1'b1);
        drain();
        // R10: alternating laws back to back, same magnitude
        for (int i = 0; i < 16; i++)
            send(16'(i * 1500), 1'(i & 1), "R10 alternating law", 1'b1);
        drain();
        // R6: sweep every table index under both laws
        for (int i = 0; i < 1024; i++) begin
            send(16'(i * 32 + 7), 1'b0, "R6 index sweep mu", 1'b1);
            send(16'(-(i * 32 + 5)), 1'b1, "R6 index sweep A", 1'b1);
        end
        drain();
        // R4 R10: backpressure with mixed laws and signs
        bp = 1'b1;
        for (int i = 0; i < 400; i++)
            send(lfsr ^ 16'(i * 97), lfsr[3], "R4 backpressure", 1'b0);
        bp = 1'b0;
        drain();
        check("R2 scoreboard empty", 32'(sb.size()), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule